// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter with Handshake Interrupts

This block gives a processor two 8-bit parallel ports, A and B. Each port has a direction register, an output register and a control register. The direction register and the output register share one address, and a control bit picks which of the two that address reaches. Each port also has two handshake lines. The first is an input that reacts to edges. The second can be an edge input or an output, and as an output it runs either as a level that software sets or as an automatic strobe. Active edges set interrupt flags, and each port drives its own interrupt request.

Software reaches the block through a plain register bus with a two-bit offset. Offset 0 is the port A data location, 1 is control A, 2 is the port B data location and 3 is control B. The bus has no back-pressure, so every access completes in the cycle it is presented. Read data is combinational from the offset. Any side effect of a read (flag clear, strobe) happens at the clock edge that ends the access. The handshake inputs are asynchronous and pass through a two-stage synchroniser before edges are detected.

Control register fields, by bit position:
- bit 0: line-1 interrupt enable.
- bit 1: line-1 active edge (1 = rising, 0 = falling).
- bit 2: data-location select (0 = direction register, 1 = output register / pin value).
- bit 3: line-2 interrupt enable in input mode; line-2 level in set mode; strobe-release select in strobe mode.
- bit 4: line-2 active edge in input mode (1 = rising). When line 2 is an output, 1 selects set mode and 0 selects strobe mode.
- bit 5: line-2 direction (1 = output).
- bit 6: line-2 flag (read-only).
- bit 7: line-1 flag (read-only).

Top module: `pio_adapter`

## Requirements
- R1: After reset, the direction, output and control registers of both ports read zero, both flags are clear, both interrupt outputs are low, and both second lines are inputs (`ca2_oe`/`cb2_oe` low).
- R2: A write to a port's data offset goes to its direction register when control bit 2 is 0 and to its output register when bit 2 is 1. A read with bit 2 at 0 returns the direction register.
- R3: The line-1 flag (control bit 7) sets only on a synchronised transition of the polarity chosen by control bit 1. A steady level or the opposite transition leaves it unchanged.
- R4: A control write stores bits 5..0 only. Bits 7 and 6 always read back as the flags and cannot be written.
- R5: A read of the data offset with control bit 2 at 1 clears both flags of that port. A read with bit 2 at 0 leaves them set. An active edge arriving in the same cycle as the clear wins, and its flag stays set.
- R6: A port's interrupt output equals (flag1 AND bit 0) OR (flag2 AND bit 3 AND NOT bit 5). It follows flag and control changes immediately, with no extra register.
- R7: With bit 5 at 0, line 2 is an input. Its flag (bit 6) sets on the edge chosen by bit 4 and reaches the interrupt output when bit 3 is 1.
- R8: With bits 5 and 4 both at 1, the second-line output equals bit 3 from the control write onward, and its output enable is high.
- R9: Port A strobe mode (bits 5,4 = 1,0) drives `ca2_out` low after a read of the data offset with bit 2 at 1. With bit 3 at 1 it returns high one cycle later. With bit 3 at 0 it stays low until an active line-1 edge.
- R10: Port B strobe mode drives `cb2_out` low after a write to the data offset with bit 2 at 1. Reads do not strobe it. With bit 3 at 1 it returns high one cycle later. With bit 3 at 0 it returns high only when a port B data read finds the line-1 flag set and clears it.
- R11: A data read with bit 2 at 1 returns, per bit, the output register where the direction bit is 1 and the external pin where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (zero when no read) |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output register |
| pa_dir | output | 8 | Port A direction register (1 = output) |
| ca1 | input | 1 | Port A line 1, edge input |
| ca2_in | input | 1 | Port A line 2 input value |
| ca2_out | output | 1 | Port A line 2 output value |
| ca2_oe | output | 1 | Port A line 2 output enable |
| irq_a | output | 1 | Port A interrupt request |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output register |
| pb_dir | output | 8 | Port B direction register (1 = output) |
| cb1 | input | 1 | Port B line 1, edge input |
| cb2_in | input | 1 | Port B line 2 input value |
| cb2_out | output | 1 | Port B line 2 output value |
| cb2_oe | output | 1 | Port B line 2 output enable |
| irq_b | output | 1 | Port B interrupt request |

## Verification
The hardest state to reach is port B's released-by-flag strobe. The line must be pulled low by a data write, must stay low through a data read made while the flag is still clear, and must then return high only on a read made after a synchronised line-1 edge has set the flag. The stimulus writes the output register in that mode and makes the read with no flag set, then checks that the line is still low. It then toggles `cb1`, waits out the synchroniser latency, and makes the releasing read. For port A, the line-1 edge that ends the strobe must move in the active direction, so the bench first parks the pin at the opposite level under a polarity that ignores it.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    OFS_A_DATA = 2'd0,
    OFS_A_CTRL = 2'd1,
    OFS_B_DATA = 2'd2,
    OFS_B_CTRL = 2'd3
  } pio_ofs_e;

  localparam int unsigned CB_L1_IEN   = 0;
  localparam int unsigned CB_L1_RISE  = 1;
  localparam int unsigned CB_DSEL     = 2;
  localparam int unsigned CB_L2_BIT3  = 3;
  localparam int unsigned CB_L2_BIT4  = 4;
  localparam int unsigned CB_L2_OUT   = 5;
  localparam int unsigned CB_FLAG2    = 6;
  localparam int unsigned CB_FLAG1    = 7;
  localparam int unsigned CTRL_WBITS  = 6;
endpackage

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int unsigned LEN = STAGES + 1;
  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LEN-2:0], din};
  end

  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int unsigned DW           = 8,
  parameter bit          WRITE_STROBE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          wr_ctrl,
  input  logic          rd_data,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  input  logic          l1_rise,
  input  logic          l1_fall,
  input  logic          l2_rise,
  input  logic          l2_fall,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] out_q,
  output logic [7:0]    ctrl_rd,
  output logic [DW-1:0] data_rd,
  output logic          l2_out,
  output logic          l2_oe,
  output logic          irq
);
  logic [CTRL_WBITS-1:0] ctrl_q;
  logic                  flag1_q, flag2_q, l2_q;
  logic                  act1, act2, rd_clear, trig, l2_d;

  assign act1     = ctrl_q[CB_L1_RISE] ? l1_rise : l1_fall;
  assign act2     = ~ctrl_q[CB_L2_OUT] & (ctrl_q[CB_L2_BIT4] ? l2_rise : l2_fall);
  assign rd_clear = rd_data & ctrl_q[CB_DSEL];

  generate
    if (WRITE_STROBE) begin : g_wstrobe
      assign trig = wr_data & ctrl_q[CB_DSEL];
    end else begin : g_rstrobe
      assign trig = rd_data & ctrl_q[CB_DSEL];
    end
  endgenerate

  // second-line output next state
  always_comb begin
    l2_d = l2_q;
    if (wr_ctrl) begin
      if (wdata[CB_L2_OUT])
        l2_d = wdata[CB_L2_BIT4] ? wdata[CB_L2_BIT3] : 1'b1;
    end else if (ctrl_q[CB_L2_OUT] && !ctrl_q[CB_L2_BIT4]) begin
      if (trig)                       l2_d = 1'b0;
      else if (ctrl_q[CB_L2_BIT3])    l2_d = 1'b1;
      else if (WRITE_STROBE)          l2_d = (rd_clear && flag1_q) ? 1'b1 : l2_q;
      else                            l2_d = act1 ? 1'b1 : l2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      ctrl_q  <= '0;
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
      l2_q    <= 1'b0;
    end else begin
      if (wr_data && !ctrl_q[CB_DSEL]) dir_q <= wdata;
      if (wr_data &&  ctrl_q[CB_DSEL]) out_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata[CTRL_WBITS-1:0];
      if (act1)          flag1_q <= 1'b1;
      else if (rd_clear) flag1_q <= 1'b0;
      if (act2)          flag2_q <= 1'b1;
      else if (rd_clear) flag2_q <= 1'b0;
      l2_q <= l2_d;
    end
  end

  generate
    for (genvar i = 0; i < DW; i++) begin : g_bit
      assign data_rd[i] = ctrl_q[CB_DSEL] ? (dir_q[i] ? out_q[i] : pin_in[i]) : dir_q[i];
    end
  endgenerate

  assign ctrl_rd = {flag1_q, flag2_q, ctrl_q};
  assign l2_out  = l2_q;
  assign l2_oe   = ctrl_q[CB_L2_OUT];
  assign irq     = (flag1_q & ctrl_q[CB_L1_IEN])
                 | (flag2_q & ctrl_q[CB_L2_BIT3] & ~ctrl_q[CB_L2_OUT]);
endmodule

// File: rtl/pio_adapter.sv
module pio_adapter
  import pio_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_dir,
  input  logic          ca1,
  input  logic          ca2_in,
  output logic          ca2_out,
  output logic          ca2_oe,
  output logic          irq_a,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_dir,
  input  logic          cb1,
  input  logic          cb2_in,
  output logic          cb2_out,
  output logic          cb2_oe,
  output logic          irq_b
);
  localparam int unsigned NLINES = 4;

  logic [NLINES-1:0] line_raw, line_rise, line_fall;
  logic [7:0]        a_ctrl_rd, b_ctrl_rd;
  logic [DW-1:0]     a_data_rd, b_data_rd;
  logic              wr_en, rd_en;

  assign line_raw = {cb2_in, cb1, ca2_in, ca1};

  generate
    for (genvar k = 0; k < NLINES; k++) begin : g_sync
      pio_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_raw[k]),
        .rise (line_rise[k]),
        .fall (line_fall[k])
      );
    end
  endgenerate

  assign wr_en = bus_sel &  bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  pio_port #(.DW(DW), .WRITE_STROBE(1'b0)) u_port_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_data(wr_en && bus_addr == OFS_A_DATA),
    .wr_ctrl(wr_en && bus_addr == OFS_A_CTRL),
    .rd_data(rd_en && bus_addr == OFS_A_DATA),
    .wdata  (bus_wdata),
    .pin_in (pa_in),
    .l1_rise(line_rise[0]),
    .l1_fall(line_fall[0]),
    .l2_rise(line_rise[1]),
    .l2_fall(line_fall[1]),
    .dir_q  (pa_dir),
    .out_q  (pa_out),
    .ctrl_rd(a_ctrl_rd),
    .data_rd(a_data_rd),
    .l2_out (ca2_out),
    .l2_oe  (ca2_oe),
    .irq    (irq_a)
  );

  pio_port #(.DW(DW), .WRITE_STROBE(1'b1)) u_port_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_data(wr_en && bus_addr == OFS_B_DATA),
    .wr_ctrl(wr_en && bus_addr == OFS_B_CTRL),
    .rd_data(rd_en && bus_addr == OFS_B_DATA),
    .wdata  (bus_wdata),
    .pin_in (pb_in),
    .l1_rise(line_rise[2]),
    .l1_fall(line_fall[2]),
    .l2_rise(line_rise[3]),
    .l2_fall(line_fall[3]),
    .dir_q  (pb_dir),
    .out_q  (pb_out),
    .ctrl_rd(b_ctrl_rd),
    .data_rd(b_data_rd),
    .l2_out (cb2_out),
    .l2_oe  (cb2_oe),
    .irq    (irq_b)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (bus_addr)
        OFS_A_DATA: bus_rdata = a_data_rd;
        OFS_A_CTRL: bus_rdata = DW'(a_ctrl_rd);
        OFS_B_DATA: bus_rdata = b_data_rd;
        default:    bus_rdata = DW'(b_ctrl_rd);
      endcase
    end
  end
endmodule

// File: rtl/pio_adapter_chk.sv
module pio_adapter_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] pa_dir,
  input logic [7:0]    a_ctrl,
  input logic [3:0]    rise,
  input logic [3:0]    fall,
  input logic          ca2_out,
  input logic          irq_a,
  input logic          irq_b,
  input logic [7:0]    b_ctrl
);
  logic rd_a, a_act1, a_act2;
  assign rd_a   = bus_sel && !bus_wr && bus_addr == 2'd0;
  assign a_act1 = a_ctrl[1] ? rise[0] : fall[0];
  assign a_act2 = !a_ctrl[5] && (a_ctrl[4] ? rise[1] : fall[1]);

  assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd1) |=> a_ctrl[5:0] == $past(bus_wdata[5:0]));

  assert_flag_from_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_ctrl[7]) |-> $past(a_act1));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a && a_ctrl[2] && !a_act1 && !a_act2) |=> a_ctrl[7:6] == 2'b00);

  assert_irq_quiet_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ctrl[7:6] == 2'b00) |-> !irq_a);

  assert_irq_quiet_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ctrl[7:6] == 2'b00) |-> !irq_b);

  assert_set_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ctrl[5] && a_ctrl[4]) |-> ca2_out == a_ctrl[3]);

  assert_strobe_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ctrl[5:3] == 3'b101 && !ca2_out && !rd_a && !(bus_sel && bus_wr && bus_addr == 2'd1))
      |=> ca2_out);

  assert_dir_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a && !a_ctrl[2]) |-> bus_rdata == pa_dir);
endmodule

bind pio_adapter pio_adapter_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pa_dir   (pa_dir),
  .a_ctrl   (a_ctrl_rd),
  .rise     (line_rise),
  .fall     (line_fall),
  .ca2_out  (ca2_out),
  .irq_a    (irq_a),
  .irq_b    (irq_b),
  .b_ctrl   (b_ctrl_rd)
);

// File: tb/tb_pio_adapter.sv
module tb_pio_adapter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pa_in = '0, pa_out, pa_dir, pb_in = '0, pb_out, pb_dir;
  logic       ca1 = 0, ca2_in = 0, ca2_out, ca2_oe, irq_a;
  logic       cb1 = 0, cb2_in = 0, cb2_out, cb2_oe, irq_b;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #10 clk = ~clk;

  pio_adapter dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir), .ca1(ca1),
    .ca2_in(ca2_in), .ca2_out(ca2_out), .ca2_oe(ca2_oe), .irq_a(irq_a),
    .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir), .cb1(cb1),
    .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe), .irq_b(irq_b)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  // driver: issue a read and push the expected value for the monitor
  task automatic rd(input logic [1:0] a, input logic [7:0] expv, input string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(expv);
    tag_q.push_back(req);
    @(negedge clk);
    bus_sel = 0;
  endtask

  // monitor: compare read data against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (bus_sel && !bus_wr) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL scoreboard: actual %02h expected none", bus_rdata);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    check("R1 irq_a", irq_a, 0);
    check("R1 irq_b", irq_b, 0);
    check("R1 pa_dir", pa_dir, 0);
    check("R1 ca2_oe", ca2_oe, 0);
    rd(2'd1, 8'h00, "R1 ctrlA");
    rd(2'd3, 8'h00, "R1 ctrlB");

    // R2 / R11 shared data address
    wr(2'd0, 8'hF0);
    rd(2'd0, 8'hF0, "R2 dir read");
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h5A);
    check("R2 pa_out", pa_out, 8'h5A);
    check("R2 pa_dir kept", pa_dir, 8'hF0);
    pa_in = 8'h33;
    rd(2'd0, 8'h53, "R11 pin mix");

    // R4 control write keeps 5..0, R8 set mode
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h3F, "R4 ro flags");
    check("R8 ca2_oe", ca2_oe, 1);
    check("R8 ca2 high", ca2_out, 1);
    wr(2'd1, 8'h34);
    check("R8 ca2 low", ca2_out, 0);

    // R3 / R6 / R5 line 1 rising
    wr(2'd1, 8'h07);
    ca1 = 1; idle(4);
    check("R6 irq_a set", irq_a, 1);
    rd(2'd1, 8'h87, "R3 flag1 rising");
    rd(2'd0, 8'h53, "R5 clearing read");
    rd(2'd1, 8'h07, "R5 flags cleared");
    check("R6 irq_a clear", irq_a, 0);
    ca1 = 0; idle(4);
    rd(2'd1, 8'h07, "R3 wrong edge ignored");

    // R3 falling polarity
    wr(2'd1, 8'h05);
    ca1 = 1; idle(4);
    rd(2'd1, 8'h05, "R3 rising ignored");
    ca1 = 0; idle(4);
    rd(2'd1, 8'h85, "R3 flag1 falling");
    check("R6 irq_a falling", irq_a, 1);
    // R5 read with bit2 = 0 does not clear
    wr(2'd1, 8'h01);
    rd(2'd0, 8'hF0, "R5 dir read");
    rd(2'd1, 8'h81, "R5 flag kept");
    wr(2'd1, 8'h04);
    check("R6 irq masked", irq_a, 0);
    rd(2'd0, 8'h53, "R5 clearing read 2");
    rd(2'd1, 8'h04, "R5 cleared 2");

    // R7 line 2 input
    wr(2'd1, 8'h1C);
    ca2_in = 1; idle(4);
    rd(2'd1, 8'h5C, "R7 flag2");
    check("R7 irq_a", irq_a, 1);
    rd(2'd0, 8'h53, "R7 clearing read");
    rd(2'd1, 8'h1C, "R7 cleared");
    ca2_in = 0; idle(4);
    rd(2'd1, 8'h1C, "R7 wrong edge ignored");

    // R9 port A read strobe, one-cycle release
    wr(2'd1, 8'h2C);
    check("R9 idle high", ca2_out, 1);
    rd(2'd0, 8'h53, "R9 strobe read");
    check("R9 strobe low", ca2_out, 0);
    idle(1);
    check("R9 released", ca2_out, 1);

    // R9 release on line-1 edge (falling)
    ca1 = 1; idle(4);
    wr(2'd1, 8'h24);
    rd(2'd0, 8'h53, "R9 strobe read 2");
    check("R9 low after read", ca2_out, 0);
    idle(3);
    check("R9 held low", ca2_out, 0);
    ca1 = 0; idle(4);
    check("R9 released by edge", ca2_out, 1);
    rd(2'd1, 8'hA4, "R9 flag1 with strobe");
    check("R6 irq_a disabled", irq_a, 0);

    // R10 port B write strobe, release by flag-clearing read
    wr(2'd3, 8'h00);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h26);
    check("R10 cb2_oe", cb2_oe, 1);
    check("R10 idle high", cb2_out, 1);
    wr(2'd2, 8'h3C);
    check("R2 pb_out", pb_out, 8'h3C);
    check("R10 strobe low", cb2_out, 0);
    idle(3);
    check("R10 held low", cb2_out, 0);
    rd(2'd2, 8'h3C, "R10 read no flag");
    check("R10 no release", cb2_out, 0);
    cb1 = 1; idle(4);
    check("R10 edge no release", cb2_out, 0);
    rd(2'd3, 8'hA6, "R10 flag1 B");
    rd(2'd2, 8'h3C, "R10 release read");
    check("R10 released", cb2_out, 1);
    rd(2'd3, 8'h26, "R10 flag cleared");

    // R10 one-cycle release, reads do not strobe
    wr(2'd3, 8'h2C);
    wr(2'd2, 8'h11);
    check("R10 short low", cb2_out, 0);
    idle(1);
    check("R10 short release", cb2_out, 1);
    rd(2'd2, 8'h11, "R10 read data");
    check("R10 read no strobe", cb2_out, 1);

    // R6 port B interrupt
    wr(2'd3, 8'h07);
    cb1 = 0; idle(4);
    cb1 = 1; idle(4);
    check("R6 irq_b", irq_b, 1);
    check("R6 irq_a independent", irq_a, 0);
    rd(2'd2, 8'h11, "R5 B clear");
    check("R6 irq_b clear", irq_b, 0);

    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule